// File: doc/BRIEF.md
# Encoded 20-to-1 Split Serializer

The block turns a stream of 16-bit words into one serial bit stream. Each word is split into a low byte and a high byte, and both are line-coded with 8B/10B. The result is a 20-bit code group per word. The low byte is coded first. Running disparity is carried from the low byte to the high byte and then on to the next word. When the word in the capture slot is not marked valid, both bytes are replaced by the K28.5 comma, so that a receiver can keep its symbol alignment on an idle link.

Serialization does not use one 20-bit shift register. Each 10-bit code segment is dealt into two 5-deep flip-flop lanes: even bit positions go to lane A and odd positions go to lane B. Both lanes shift at half the line rate. A 2:1 selector, driven by the line-clock phase, takes lane A in the first half of each bit pair and lane B in the second half. The two lanes are therefore interleaved strictly. They reload once per 10 line bits: the first segment comes straight from the encoder and the second comes from a hold register.

All timing runs on one clock qualified by a bit-rate enable. Each enabled cycle emits one line bit, which models the 2.5 Gb/s line clock. The block drives a word strobe, one enabled cycle in every 20, in the cycle where the input word is captured. This strobe stands in for the word clock.

Top module: `ser20_split`

## Requirements
- R1: While reset is held, `ser_out` is 0 and `word_tick` is 0; the first cycle after reset with `bit_en` high carries `word_tick`.
- R2: `word_tick` is high only in cycles with `bit_en` high, exactly once per 20 such cycles, and the word on `word_data`/`word_valid` is captured at that clock edge; input values in other cycles have no effect on the line.
- R3: After the capturing edge, the next 20 enabled edges each present one line bit on `ser_out`. The low byte's 10-bit symbol goes first, and inside a symbol the six-bit sub-block goes first, in the order a,b,c,d,e,i, followed by f,g,h,j.
- R4: Data bytes are coded with the standard 8B/10B tables. Byte bits [4:0] select the 5b/6b code and bits [7:5] select the 3b/4b code. A sub-block is complemented at positive disparity when it is unbalanced, and also for D.07 (6-bit) and D.x.3 (4-bit).
- R5: Running disparity starts negative after reset. Every symbol holds 4, 5 or 6 ones, and the running sum of (ones - zeros) over the line stays at 0 or +2.
- R6: A word captured with `word_valid` low is sent as two K28.5 symbols: 0011111010 at negative running disparity and 1100000101 at positive, written in transmission order.
- R7: In a cycle with `bit_en` low, `ser_out` holds its value over the following edge.
- R8: D.x.7 uses the alternate 4-bit code (0111/1000) when the running disparity after the 6-bit sub-block is negative and x is 17, 18 or 20, or when it is positive and x is 11, 13 or 14. Otherwise D.x.7 uses the primary code (1110/0001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; one line bit per enabled cycle |
| word_data | input | 16 | Parallel data word, low byte in bits [7:0] |
| word_valid | input | 1 | Word is data when high; comma fill when low |
| word_tick | output | 1 | Word strobe: the input word is captured at this edge |
| ser_out | output | 1 | Serial line bit |

## Verification
A wrong phase count or a wrong lane load shows on the line within one word. The 20 bits gathered after a strobe then no longer match the bench's own coding of the captured word, and the strobe drifts from its 20-enabled-edge grid. A wrong running-disparity state may let a single symbol still look legal. It breaks the expected complement choice at the next unbalanced sub-block, and it drives the line's running digital sum outside {0, +2} within two symbols. A selector that picks the wrong lane swaps adjacent bits and fails the very first data word.

// File: rtl/ser20_pkg.sv
package ser20_pkg;

  localparam int SYM_W = 10;

  // 5b/6b sub-block at negative running disparity, abcdei with a as MSB
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  // 3b/4b sub-block at negative disparity, fghj with f as MSB (primary codes)
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;  3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;  3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;  3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;  default: four_neg = 4'b1110;
    endcase
  endfunction

  // Returns {rd_after, abcdeifghj}; rd_pos=1 means positive disparity
  function automatic logic [SYM_W:0] enc_byte(input logic [7:0] d,
                                              input logic is_comma,
                                              input logic rd_pos);
    logic [5:0] s6;
    logic [3:0] s4;
    logic       rd_mid;
    logic       alt7;
    logic [4:0] x;
    logic [2:0] y;
    x = d[4:0];
    y = d[7:5];
    if (is_comma) begin
      enc_byte = rd_pos ? {1'b0, 10'b1100000101} : {1'b1, 10'b0011111010};
    end else begin
      s6 = six_neg(x);
      if (rd_pos && (($countones(s6) != 3) || (x == 5'd7))) s6 = ~s6;
      rd_mid = rd_pos ^ ($countones(s6) != 3);
      alt7 = (y == 3'd7) &&
             ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      s4 = alt7 ? 4'b0111 : four_neg(y);
      if (rd_mid && (($countones(s4) != 2) || (y == 3'd3))) s4 = ~s4;
      enc_byte = {rd_mid ^ ($countones(s4) != 2), s6, s4};
    end
  endfunction

endpackage

// File: rtl/ser20_enc.sv
module ser20_enc #(
  parameter int BYTES = 2
) (
  input  logic [BYTES*8-1:0]                 data,
  input  logic                               is_comma,
  input  logic                               rd_in,
  output logic [BYTES*ser20_pkg::SYM_W-1:0]  code,
  output logic                               rd_out
);
  import ser20_pkg::*;

  logic [BYTES:0] rd_c;
  assign rd_c[0] = rd_in;
  assign rd_out  = rd_c[BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [SYM_W:0] res;
    assign res       = enc_byte(data[b*8 +: 8], is_comma, rd_c[b]);
    assign rd_c[b+1] = res[SYM_W];
    // transmission order: code bit 0 of each symbol is sub-block bit a
    for (genvar i = 0; i < SYM_W; i++) begin : g_bit
      assign code[b*SYM_W + i] = res[SYM_W-1-i];
    end

    always_comb begin
      if (!$isunknown({rd_c[b], res})) begin
        AST_RD_BAL: assert (rd_c[b] ? ($countones(res[SYM_W-1:0]) inside {4, 5})
                                    : ($countones(res[SYM_W-1:0]) inside {5, 6})); // R5
      end
    end
  end

endmodule

// File: rtl/ser20_phase.sv
module ser20_phase #(
  parameter int PH_N     = 20,
  parameter int LANES    = 2,
  parameter int SEG_BITS = 10,
  localparam int PH_W    = $clog2(PH_N),
  localparam int SEGS    = PH_N / SEG_BITS,
  localparam int SEG_IW  = (SEGS > 1) ? $clog2(SEGS) : 1,
  localparam int LSEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  output logic              word_tick,
  output logic              seg_load,
  output logic              lane_shift,
  output logic [SEG_IW-1:0] seg_idx,
  output logic [LSEL_W-1:0] lane_sel
);

  logic [PH_W-1:0] ph;
  logic            at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= PH_W'(PH_N-1);
    else if (bit_en)  ph <= at_end ? '0 : ph + 1'b1;
  end

  always_comb begin
    at_end     = (ph == PH_W'(PH_N-1));
    word_tick  = bit_en && at_end;
    seg_load   = bit_en && ((int'(ph) % SEG_BITS) == SEG_BITS-1);
    lane_shift = bit_en && ((int'(ph) % LANES) == LANES-1) && !seg_load;
    seg_idx    = at_end ? '0 : SEG_IW'((int'(ph) + 1) / SEG_BITS);
    lane_sel   = LSEL_W'(int'(ph) % LANES);
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick |=> (ph == '0)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !word_tick) |=> (ph == $past(ph) + 1'b1)); // R2
  AST_LOAD_AT_PAIR_END: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |-> (lane_sel == LSEL_W'(LANES-1))); // R3

endmodule

// File: rtl/ser20_lane.sv
module ser20_lane #(
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [DEPTH-1:0] load_bits,
  output logic             lane_bit
);

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr <= '0;
    else if (load)   sr <= load_bits;
    else if (shift)  sr <= {1'b0, sr[DEPTH-1:1]};
  end

  assign lane_bit = sr[0];

  AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R3

endmodule

// File: rtl/ser20_split.sv
module ser20_split #(
  parameter int WORD_W     = 16,
  parameter int LANES      = 2,
  parameter int LANE_DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_tick,
  output logic              ser_out
);
  import ser20_pkg::*;

  localparam int BYTES    = WORD_W / 8;
  localparam int CODE_W   = BYTES * SYM_W;
  localparam int SEG_BITS = LANES * LANE_DEPTH;
  localparam int SEGS     = CODE_W / SEG_BITS;
  localparam int HOLD_W   = CODE_W - SEG_BITS;
  localparam int SEG_IW   = (SEGS > 1) ? $clog2(SEGS) : 1;
  localparam int LSEL_W   = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CODE_W-1:0]   enc_code;
  logic                enc_rd;
  logic                rd_q;
  logic [HOLD_W-1:0]   hold_q;
  logic                seg_load;
  logic                lane_shift;
  logic [SEG_IW-1:0]   seg_idx;
  logic [LSEL_W-1:0]   lane_sel;
  logic [SEG_BITS-1:0] seg_bits;
  logic [LANES-1:0]    lane_out;

  ser20_enc #(.BYTES(BYTES)) u_enc (
    .data     (word_data),
    .is_comma (~word_valid),
    .rd_in    (rd_q),
    .code     (enc_code),
    .rd_out   (enc_rd)
  );

  ser20_phase #(.PH_N(CODE_W), .LANES(LANES), .SEG_BITS(SEG_BITS)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .word_tick  (word_tick),
    .seg_load   (seg_load),
    .lane_shift (lane_shift),
    .seg_idx    (seg_idx),
    .lane_sel   (lane_sel)
  );

  // running disparity and the not-yet-sent segments of the current word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      hold_q <= '0;
    end else if (word_tick) begin
      rd_q   <= enc_rd;
      hold_q <= enc_code[CODE_W-1:SEG_BITS];
    end
  end

  // first segment goes straight from the encoder, later ones from the hold
  always_comb begin
    if (seg_idx == '0) seg_bits = enc_code[SEG_BITS-1:0];
    else               seg_bits = hold_q[(int'(seg_idx)-1)*SEG_BITS +: SEG_BITS];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_DEPTH-1:0] lane_load;
    for (genvar j = 0; j < LANE_DEPTH; j++) begin : g_tap
      assign lane_load[j] = seg_bits[l + LANES*j];
    end
    ser20_lane #(.DEPTH(LANE_DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (seg_load),
      .shift     (lane_shift),
      .load_bits (lane_load),
      .lane_bit  (lane_out[l])
    );
  end

  // 2:1 (LANES:1) interleave selected by line-clock phase
  assign ser_out = lane_out[lane_sel];

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out)); // R7
  AST_IDLE_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && !word_valid) |=>
      (hold_q[SYM_W-1:0] == 10'h17C || hold_q[SYM_W-1:0] == 10'h283)); // R6

endmodule

// File: tb/tb_ser20_split.sv
module tb_ser20_split;

  localparam int NW = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en;
  logic [15:0] word_data;
  logic        word_valid;
  logic        word_tick;
  logic        ser_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ser20_split dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_data(word_data),
    .word_valid(word_valid), .word_tick(word_tick), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [5:0] tb_six(input int x);
    bit [5:0] t [32] = '{6'h27,6'h1D,6'h2D,6'h31,6'h35,6'h29,6'h19,6'h38,
                         6'h39,6'h25,6'h15,6'h34,6'h0D,6'h2C,6'h1C,6'h17,
                         6'h1B,6'h23,6'h13,6'h32,6'h0B,6'h2A,6'h1A,6'h3A,
                         6'h33,6'h26,6'h16,6'h36,6'h0E,6'h2E,6'h1E,6'h2B};
    return t[x];
  endfunction

  function automatic bit [3:0] tb_four(input int y);
    bit [3:0] t [8] = '{4'hB,4'h9,4'h5,4'hC,4'hD,4'hA,4'h6,4'hE};
    return t[y];
  endfunction

  // returns {rd_after, symbol} with symbol bit 0 = first bit on the line
  function automatic bit [10:0] tb_enc(input bit [7:0] d, input bit comma, input bit rd);
    bit [9:0] notation;
    bit [9:0] sym;
    bit [5:0] s6;
    bit [3:0] s4;
    bit rm;
    int x, y;
    x = d[4:0];
    y = d[7:5];
    if (comma) notation = rd ? 10'b1100000101 : 10'b0011111010;
    else begin
      s6 = tb_six(x);
      if (rd && ($countones(s6) != 3 || x == 7)) s6 = ~s6;
      rm = rd ^ ($countones(s6) != 3);
      if (y == 7 && ((!rm && (x == 17 || x == 18 || x == 20)) ||
                     (rm && (x == 11 || x == 13 || x == 14)))) s4 = 4'b0111;
      else s4 = tb_four(y);
      if (rm && ($countones(s4) != 2 || y == 3)) s4 = ~s4;
      notation = {s6, s4};
    end
    for (int i = 0; i < 10; i++) sym[i] = notation[9-i];
    return {rd ^ ($countones(sym) != 5), sym};
  endfunction

  bit [15:0] exp_d [NW+8];
  bit        exp_v [NW+8];
  bit        bits  [20];
  bit        rd_tb = 0;
  int        dsum = 0;
  int        nbits = 0;
  int        nwords = 0;

  task automatic check_word(input int w);
    bit [9:0]  got;
    bit [10:0] e;
    bit [7:0]  by;
    string     tag;
    for (int s = 0; s < 2; s++) begin
      by = (s == 0) ? exp_d[w][7:0] : exp_d[w][15:8];
      for (int i = 0; i < 10; i++) got[i] = bits[s*10 + i];
      e = tb_enc(by, !exp_v[w], rd_tb);
      if (!exp_v[w])          tag = "R6 comma symbol";
      else if (by[7:5] == 7)  tag = "R8 D.x.7 symbol";
      else if (s == 0)        tag = "R3 low byte symbol first";
      else                    tag = "R4 high byte symbol";
      chk(got == e[9:0], tag, got, e[9:0]);
      rd_tb = e[10];
      dsum += 2*$countones(got) - 10;
      chk(dsum == 0 || dsum == 2, "R5 running digital sum", dsum, rd_tb ? 2 : 0);
    end
  endtask

  initial begin
    int unsigned seed;
    bit last_en;
    bit last_ser;
    bit en;
    bit tick_exp;
    int cyc;
    int w;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bit_en = 1'b0; word_data = 16'h0; word_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(ser_out == 1'b0, "R1 reset ser_out", ser_out, 0);
    chk(word_tick == 1'b0, "R1 reset word_tick", word_tick, 0);
    rst_n = 1'b1;
    last_en = 0; last_ser = ser_out; cyc = 0;
    while (nwords < NW) begin
      @(negedge clk);
      // observe result of the previous edge
      if (last_en) begin
        bits[nbits % 20] = ser_out;
        nbits++;
        if (nbits % 20 == 0) begin
          check_word(nbits/20 - 1);
          nwords++;
        end
      end else if (cyc > 0) begin
        chk(ser_out == last_ser, "R7 hold without bit_en", ser_out, last_ser);
      end
      // drive the next cycle
      en = (cyc < 40) ? 1'b1 : (($urandom % 4) != 0);
      tick_exp = en && (nbits % 20 == 0);
      if (tick_exp) begin
        w = nbits / 20;
        case (w)
          0: begin word_data = 16'h0000; word_valid = 1; end
          1: begin word_data = 16'hFFFF; word_valid = 1; end
          2: begin word_data = 16'hF1F1; word_valid = 1; end
          3: begin word_data = 16'hEBF2; word_valid = 1; end
          4: begin word_data = 16'hEDF4; word_valid = 1; end
          5: begin word_data = 16'hBCEE; word_valid = 1; end
          6, 7: begin word_data = 16'h1234; word_valid = 0; end
          8: begin word_data = 16'h07E7; word_valid = 1; end
          9: begin word_data = 16'h63A3; word_valid = 1; end
          default: begin
            word_data  = 16'($urandom);
            word_valid = (($urandom % 5) != 0);
          end
        endcase
        if (w < NW + 8) begin exp_d[w] = word_data; exp_v[w] = word_valid; end
      end else begin
        // values outside the capture slot must not reach the line (R2)
        word_data  = 16'($urandom);
        word_valid = $urandom % 2;
      end
      bit_en = en;
      #1;
      if (cyc == 0) chk(word_tick == 1'b1, "R1 first enabled cycle strobes", word_tick, 1);
      else          chk(word_tick == tick_exp, "R2 word strobe grid", word_tick, tick_exp);
      last_en = en;
      last_ser = ser_out;
      cyc++;
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d words expected=%0d", nwords, NW);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule